// File: doc/BRIEF.md
# Real-Time Counter with Time-of-Day and Sub-Second Alarms

This block keeps time from a 256 Hz tick strobe that is already derived from a 32.768 kHz oscillator. It holds an 8-bit fraction-of-second counter and a 32-bit seconds counter. Two alarms are built in: a time-of-day alarm that compares the seconds count, and a periodic sub-second alarm that counts ticks down from a reload value. Software reaches every register over a simple single-cycle register bus. The block drives an interrupt line and a wake line.

The enable bits live in the control word. They are protected in two ways. First, an enable change is accepted only while a separately written write-enable bit is already set. Second, an accepted change only becomes effective after a busy period. The busy period stands for the hand-off into the slow clock domain. Each count update also drives a ready flag. The flag drops in the cycle after a tick and rises when the counters take their new value. Software can therefore tell that a consistent count has just been loaded.

Top module: `rtc_alarm_core`

## Requirements
- R1: After reset the control word reads 0x00000008, the seconds and fraction counters read 0, and `irq` and `wake` are low.
- R2: While the clock runs, each tick advances the fraction counter by one. The seconds counter advances exactly when the fraction counter wraps from 0xFF to 0x00, and it wraps from 0xFFFFFFFF to 0.
- R3: A tick sampled on one clock edge clears ready (control bit 4) on that edge. The counters take their new value, and ready returns to 1, on the following edge.
- R4: A control write with bit 4 = 0 clears ready. Writing bit 4 = 1 never sets ready.
- R5: Control bits 0 (run), 1 (time-of-day interrupt enable) and 2 (sub-second interrupt enable) accept a new value only when write-enable (bit 15, stored by an earlier control write) is 1 and busy (bit 3) is 0. Any other attempt is ignored.
- R6: An accepted change to bits 0 to 2 sets busy. Those bits keep reading their old value until busy falls on the second tick after the write, and then they read the new value. A write of the value those bits already hold does not set busy.
- R7: Busy reads 1 out of reset and falls on the second tick.
- R8: The seconds counter (address 0) and the fraction counter (address 1) accept a write only while the clock is stopped. Writes while it runs are ignored.
- R9: The time-of-day flag (control bit 6) sets when the seconds counter steps to a value whose low 20 bits equal the 20-bit alarm register (address 2). Writing that register clears the flag.
- R10: Writing the 32-bit reload register (address 3) loads the sub-second down-counter and clears the sub-second flag (control bit 7). When the reload value is R > 0, the flag sets on the R-th count update and the counter reloads. A reload value of 0 never sets the flag.
- R11: `irq` is the OR of (bit 6 AND bit 1), (bit 7 AND bit 2) and (ready AND bit 5). `wake` is the OR of the two enabled alarm flags. The flags set whatever their enables are.
- R12: Register addresses are 0 seconds, 1 fraction, 2 time-of-day alarm, 3 reload, 4 control. Any other address reads 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick | input | 1 | One-cycle 256 Hz strobe |
| bus_wr | input | 1 | Register write strobe |
| bus_addr | input | 3 | Register word address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for bus_addr, combinational |
| irq | output | 1 | Interrupt request |
| wake | output | 1 | Wake-up request from enabled alarms |

## Verification
The counting path is driven by random tick bursts from random start times. The start times are biased toward fraction values near 0xFF, so bursts that stay inside one second can be told apart from bursts that carry into the seconds counter, and the all-ones seconds value checks the 32-bit wrap. Directed sequences separate write attempts made without write-enable, during busy, and with an unchanged value. Each of these must leave the effective bits alone, while only a real change opens the two-tick window. The alarm sequences set flags with their enables off and then on, which tells flag setting apart from interrupt gating. They also rewrite the reload register at different points, which separates reload timing from flag clearing.

// File: rtl/rtc_alarm_pkg.sv
package rtc_alarm_pkg;
   typedef enum logic [2:0] {
      RA_SEC  = 3'd0,
      RA_FRAC = 3'd1,
      RA_TOD  = 3'd2,
      RA_RLD  = 3'd3,
      RA_CTRL = 3'd4
   } reg_addr_e;

   localparam int CB_RUN   = 0;
   localparam int CB_TODIE = 1;
   localparam int CB_SSIE  = 2;
   localparam int CB_BUSY  = 3;
   localparam int CB_RDY   = 4;
   localparam int CB_RDYIE = 5;
   localparam int CB_TODF  = 6;
   localparam int CB_SSF   = 7;
   localparam int CB_WE    = 15;
   localparam int N_GUARD  = 3;

   typedef struct packed {
      logic ss_ie;
      logic tod_ie;
      logic run;
   } guard_bits_t;
endpackage

// File: rtl/rtc_timebase.sv
module rtc_timebase #(
   parameter int SEC_W   = 32,
   parameter int FRAC_W  = 8,
   parameter int MATCH_W = 20
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               step,
   input  logic               ld_sec,
   input  logic               ld_frac,
   input  logic [SEC_W-1:0]   ld_data,
   input  logic [MATCH_W-1:0] match_val,
   output logic [SEC_W-1:0]   sec,
   output logic [FRAC_W-1:0]  frac,
   output logic               match_hit
);
   logic               wrap;
   logic               sec_step;
   logic [SEC_W-1:0]   sec_inc;

   assign wrap      = &frac;
   assign sec_step  = step && wrap && !ld_sec;
   assign sec_inc   = sec + SEC_W'(1);
   assign match_hit = sec_step && (sec_inc[MATCH_W-1:0] == match_val);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sec  <= '0;
         frac <= '0;
      end else begin
         if (ld_sec)
            sec <= ld_data;
         else if (sec_step)
            sec <= sec_inc;
         if (ld_frac)
            frac <= ld_data[FRAC_W-1:0];
         else if (step)
            frac <= frac + FRAC_W'(1);
      end
   end
endmodule

// File: rtl/rtc_ss_alarm.sv
module rtc_ss_alarm #(
   parameter int W = 32
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         step,
   input  logic         load,
   input  logic [W-1:0] load_val,
   output logic [W-1:0] reload,
   output logic         fire
);
   logic [W-1:0] cnt;
   logic         armed;
   logic         at_end;

   assign armed  = (reload != '0);
   assign at_end = (cnt <= W'(1));
   assign fire   = step && !load && armed && at_end;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         reload <= '0;
         cnt    <= '0;
      end else if (load) begin
         reload <= load_val;
         cnt    <= load_val;
      end else if (step && armed) begin
         cnt <= at_end ? reload : cnt - W'(1);
      end
   end
endmodule

// File: rtl/rtc_ctrl_sync.sv
module rtc_ctrl_sync
   import rtc_alarm_pkg::*;
#(
   parameter int SYNC_TICKS = 2
) (
   input  logic        clk,
   input  logic        rst_n,
   input  logic        tick,
   input  logic        req,
   input  logic        allow,
   input  guard_bits_t req_val,
   output logic        busy,
   output guard_bits_t active
);
   localparam int CNT_W = $clog2(SYNC_TICKS + 1);

   guard_bits_t      pend;
   logic [CNT_W-1:0] cnt;
   logic             take;
   logic             last;

   assign take = req && allow && !busy && (req_val != active);
   assign last = (cnt == CNT_W'(SYNC_TICKS - 1));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         busy   <= 1'b1;
         cnt    <= '0;
         pend   <= '0;
         active <= '0;
      end else if (busy) begin
         if (tick) begin
            if (last) begin
               busy   <= 1'b0;
               active <= pend;
               cnt    <= '0;
            end else begin
               cnt <= cnt + CNT_W'(1);
            end
         end
      end else if (take) begin
         pend <= req_val;
         busy <= 1'b1;
         cnt  <= '0;
      end
   end
endmodule

// File: rtl/rtc_alarm_core.sv
module rtc_alarm_core
   import rtc_alarm_pkg::*;
#(
   parameter int DATA_W     = 32,
   parameter int SEC_W      = 32,
   parameter int FRAC_W     = 8,
   parameter int TOD_W      = 20,
   parameter int RLD_W      = 32,
   parameter int SYNC_TICKS = 2,
   parameter bit IRQ_REG    = 1'b0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              tick,
   input  logic              bus_wr,
   input  logic [2:0]        bus_addr,
   input  logic [DATA_W-1:0] bus_wdata,
   output logic [DATA_W-1:0] bus_rdata,
   output logic              irq,
   output logic              wake
);
   generate
      if (SEC_W > DATA_W || RLD_W > DATA_W || FRAC_W > SEC_W)
         $error("rtc_alarm_core: counter wider than the bus");
      if (TOD_W > SEC_W || TOD_W < 1)
         $error("rtc_alarm_core: alarm width out of range");
      if (SYNC_TICKS < 1)
         $error("rtc_alarm_core: sync window needs at least one tick");
      if (DATA_W <= CB_WE)
         $error("rtc_alarm_core: bus too narrow for control word");
   endgenerate

   logic               wr_sec, wr_frac, wr_tod, wr_rld, wr_ctrl;
   logic               busy_w;
   guard_bits_t        act_w;
   guard_bits_t        req_bits;
   logic               we_q, rdy_ie_q, ready_q, upd_q;
   logic               tod_flag_q, ss_flag_q;
   logic [TOD_W-1:0]   tod_q;
   logic [SEC_W-1:0]   sec_w;
   logic [FRAC_W-1:0]  frac_w;
   logic [RLD_W-1:0]   reload_w;
   logic               tod_hit, ss_fire;
   logic               run;
   logic [DATA_W-1:0]  ctrl_word;
   logic               irq_d, wake_d;

   assign run     = act_w.run;
   assign wr_sec  = bus_wr && (bus_addr == RA_SEC)  && !run;
   assign wr_frac = bus_wr && (bus_addr == RA_FRAC) && !run;
   assign wr_tod  = bus_wr && (bus_addr == RA_TOD);
   assign wr_rld  = bus_wr && (bus_addr == RA_RLD);
   assign wr_ctrl = bus_wr && (bus_addr == RA_CTRL);

   assign req_bits.run    = bus_wdata[CB_RUN];
   assign req_bits.tod_ie = bus_wdata[CB_TODIE];
   assign req_bits.ss_ie  = bus_wdata[CB_SSIE];

   rtc_ctrl_sync #(.SYNC_TICKS(SYNC_TICKS)) u_sync (
      .clk     (clk),
      .rst_n   (rst_n),
      .tick    (tick),
      .req     (wr_ctrl),
      .allow   (we_q),
      .req_val (req_bits),
      .busy    (busy_w),
      .active  (act_w)
   );

   rtc_timebase #(.SEC_W(SEC_W), .FRAC_W(FRAC_W), .MATCH_W(TOD_W)) u_tb (
      .clk       (clk),
      .rst_n     (rst_n),
      .step      (upd_q),
      .ld_sec    (wr_sec),
      .ld_frac   (wr_frac),
      .ld_data   (bus_wdata[SEC_W-1:0]),
      .match_val (tod_q),
      .sec       (sec_w),
      .frac      (frac_w),
      .match_hit (tod_hit)
   );

   rtc_ss_alarm #(.W(RLD_W)) u_ss (
      .clk      (clk),
      .rst_n    (rst_n),
      .step     (upd_q),
      .load     (wr_rld),
      .load_val (bus_wdata[RLD_W-1:0]),
      .reload   (reload_w),
      .fire     (ss_fire)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         we_q       <= 1'b0;
         rdy_ie_q   <= 1'b0;
         ready_q    <= 1'b0;
         upd_q      <= 1'b0;
         tod_q      <= '0;
         tod_flag_q <= 1'b0;
         ss_flag_q  <= 1'b0;
      end else begin
         upd_q <= tick && run;
         if (wr_ctrl) begin
            we_q     <= bus_wdata[CB_WE];
            rdy_ie_q <= bus_wdata[CB_RDYIE];
         end
         if (upd_q)
            ready_q <= 1'b1;
         else if (tick && run)
            ready_q <= 1'b0;
         else if (wr_ctrl && !bus_wdata[CB_RDY])
            ready_q <= 1'b0;
         if (wr_tod)
            tod_q <= bus_wdata[TOD_W-1:0];
         if (tod_hit)
            tod_flag_q <= 1'b1;
         else if (wr_tod)
            tod_flag_q <= 1'b0;
         if (ss_fire)
            ss_flag_q <= 1'b1;
         else if (wr_rld)
            ss_flag_q <= 1'b0;
      end
   end

   always_comb begin
      ctrl_word           = '0;
      ctrl_word[CB_RUN]   = act_w.run;
      ctrl_word[CB_TODIE] = act_w.tod_ie;
      ctrl_word[CB_SSIE]  = act_w.ss_ie;
      ctrl_word[CB_BUSY]  = busy_w;
      ctrl_word[CB_RDY]   = ready_q;
      ctrl_word[CB_RDYIE] = rdy_ie_q;
      ctrl_word[CB_TODF]  = tod_flag_q;
      ctrl_word[CB_SSF]   = ss_flag_q;
      ctrl_word[CB_WE]    = we_q;
   end

   always_comb begin
      case (bus_addr)
         RA_SEC:  bus_rdata = DATA_W'(sec_w);
         RA_FRAC: bus_rdata = DATA_W'(frac_w);
         RA_TOD:  bus_rdata = DATA_W'(tod_q);
         RA_RLD:  bus_rdata = DATA_W'(reload_w);
         RA_CTRL: bus_rdata = ctrl_word;
         default: bus_rdata = '0;
      endcase
   end

   assign wake_d = (tod_flag_q && act_w.tod_ie) || (ss_flag_q && act_w.ss_ie);
   assign irq_d  = wake_d || (ready_q && rdy_ie_q);

   generate
      if (IRQ_REG) begin : g_irq_reg
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               irq  <= 1'b0;
               wake <= 1'b0;
            end else begin
               irq  <= irq_d;
               wake <= wake_d;
            end
         end
      end else begin : g_irq_comb
         assign irq  = irq_d;
         assign wake = wake_d;
      end
   endgenerate
endmodule

// File: rtl/rtc_alarm_core_chk.sv
module rtc_alarm_core_chk #(
   parameter int  SEC_W   = 32,
   parameter int  FRAC_W  = 8,
   parameter bit  IRQ_REG = 1'b0
) (
   input logic              clk,
   input logic              rst_n,
   input logic [SEC_W-1:0]  sec,
   input logic [FRAC_W-1:0] frac,
   input logic              ld_sec,
   input logic              busy,
   input logic              we,
   input logic [2:0]        act,
   input logic              ready,
   input logic              tod_flag,
   input logic              ss_flag,
   input logic              irq,
   input logic              wake
);
   // R2
   sec_carry_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!$stable(sec) && !$past(ld_sec)) |-> (frac == '0));

   // R5
   we_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(busy) |-> $past(we));

   // R6
   act_change_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !$stable(act) |-> $fell(busy));

   // R3
   ready_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(ready) |-> !$stable(frac));

   // R11
   irq_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!IRQ_REG && irq) |-> (tod_flag || ss_flag || ready));

   // R11
   wake_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!IRQ_REG && wake) |-> (tod_flag || ss_flag));
endmodule

bind rtc_alarm_core rtc_alarm_core_chk #(
   .SEC_W(SEC_W), .FRAC_W(FRAC_W), .IRQ_REG(IRQ_REG)
) u_chk (
   .clk      (clk),
   .rst_n    (rst_n),
   .sec      (sec_w),
   .frac     (frac_w),
   .ld_sec   (wr_sec),
   .busy     (busy_w),
   .we       (we_q),
   .act      (act_w),
   .ready    (ready_q),
   .tod_flag (tod_flag_q),
   .ss_flag  (ss_flag_q),
   .irq      (irq),
   .wake     (wake)
);

// File: tb/rtc_alarm_core_tb.sv
module rtc_alarm_core_tb;
   localparam int CLK_PERIOD = 10;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        tick = 1'b0;
   logic        bus_wr = 1'b0;
   logic [2:0]  bus_addr = 3'd0;
   logic [31:0] bus_wdata = '0;
   logic [31:0] bus_rdata;
   logic        irq, wake;
   int          checks = 0;
   int          errors = 0;
   bit          done = 0;

   rtc_alarm_core u_dut (
      .clk(clk), .rst_n(rst_n), .tick(tick), .bus_wr(bus_wr),
      .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
      .irq(irq), .wake(wake)
   );

   always #(CLK_PERIOD/2) clk = ~clk;

   task automatic chk(input string req, input string what,
                      input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
      end
   endtask

   task automatic wr(input logic [2:0] a, input logic [31:0] d);
      @(negedge clk);
      bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
      @(negedge clk);
      bus_wr = 1'b0;
   endtask

   task automatic rd(input logic [2:0] a, output logic [31:0] d);
      bus_addr = a;
      #1;
      d = bus_rdata;
   endtask

   task automatic do_tick();
      @(negedge clk); tick = 1'b1;
      @(negedge clk); tick = 1'b0;
      @(negedge clk);
      @(negedge clk);
   endtask

   task automatic ticks(input int n);
      for (int i = 0; i < n; i++) do_tick();
   endtask

   function automatic logic [39:0] advance(input logic [31:0] s,
                                           input logic [7:0] f, input int n);
      return {s, f} + 40'(n);
   endfunction

   // stop, load a time, restart: leaves the clock running, ctrl = we|run
   task automatic set_time(input logic [31:0] s, input logic [7:0] f,
                           input logic [31:0] run_word);
      wr(3'd4, 32'h8000);
      ticks(2);
      wr(3'd0, s);
      wr(3'd1, {24'd0, f});
      wr(3'd4, run_word);
      ticks(2);
   endtask

   task automatic finish_run();
      if (!done) begin
         done = 1;
         $display("  CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   endtask

   initial begin
      #(CLK_PERIOD * 150000);
      errors++;
      $display("FAIL watchdog expired");
      finish_run();
   end

   initial begin
      logic [31:0] v, v2;
      logic [39:0] e;
      void'($urandom(32'h5EED));

      repeat (3) @(negedge clk);
      rd(3'd4, v); chk("R1", "ctrl in reset", v, 32'h8);
      rst_n = 1'b1;
      @(negedge clk);
      rd(3'd4, v); chk("R1", "ctrl after reset", v, 32'h8);
      rd(3'd0, v); chk("R1", "seconds", v, 0);
      rd(3'd1, v); chk("R1", "fraction", v, 0);
      chk("R1", "irq/wake", {30'd0, irq, wake}, 0);

      // R7 busy clears after two ticks
      do_tick();
      rd(3'd4, v); chk("R7", "busy after one tick", v, 32'h8);
      do_tick();
      rd(3'd4, v); chk("R7", "busy after two ticks", v, 32'h0);

      // R5 no write-enable stored: ignored
      wr(3'd4, 32'h0001);
      rd(3'd4, v); chk("R5", "enable without we", v, 32'h0);
      wr(3'd4, 32'h8000);
      rd(3'd4, v); chk("R6", "same value no busy", v, 32'h8000);
      wr(3'd4, 32'h8001);
      rd(3'd4, v); chk("R6", "busy, run not yet", v, 32'h8008);
      wr(3'd4, 32'h8000);   // R5 attempt during busy is ignored
      do_tick();
      rd(3'd4, v); chk("R6", "still busy after one tick", v, 32'h8008);
      do_tick();
      rd(3'd4, v); chk("R5", "run applied, busy-time write ignored", v, 32'h8001);

      // R2 / R3 counting and ready timing
      do_tick();
      rd(3'd1, v); chk("R2", "fraction after one tick", v, 1);
      rd(3'd4, v); chk("R3", "ready set after update", v[4], 1);
      @(negedge clk); tick = 1'b1;
      @(negedge clk); tick = 1'b0;
      rd(3'd4, v); chk("R3", "ready dropped before update", v[4], 0);
      rd(3'd1, v); chk("R3", "fraction not yet updated", v, 1);
      @(negedge clk);
      rd(3'd4, v); chk("R3", "ready back with update", v[4], 1);
      rd(3'd1, v); chk("R3", "fraction updated", v, 2);

      // R4 software clear of ready
      wr(3'd4, 32'h8001);
      rd(3'd4, v); chk("R4", "ready cleared", v, 32'h8001);
      wr(3'd4, 32'h8011);
      rd(3'd4, v); chk("R4", "writing 1 does not set ready", v, 32'h8001);

      // R8 writes ignored while running
      wr(3'd0, 32'd5);
      wr(3'd1, 32'd77);
      rd(3'd0, v); chk("R8", "seconds write ignored", v, 0);
      rd(3'd1, v); chk("R8", "fraction write ignored", v, 2);

      // R2 random bursts from random start times
      for (int it = 0; it < 6; it++) begin
         logic [31:0] s0;
         logic [7:0]  f0;
         int          n;
         s0 = $urandom;
         f0 = (it % 2 == 0) ? 8'(8'hE0 + ($urandom % 32)) : 8'($urandom);
         n  = int'($urandom % 600);
         set_time(s0, f0, 32'h8001);
         rd(3'd0, v); chk("R8", "seconds loaded while stopped", v, s0);
         ticks(n);
         e = advance(s0, f0, n);
         rd(3'd0, v); chk("R2", "random seconds", v, e[39:8]);
         rd(3'd1, v); chk("R2", "random fraction", v, {24'd0, e[7:0]});
      end

      // R2 seconds wrap
      set_time(32'hFFFF_FFFF, 8'hFE, 32'h8001);
      ticks(2);
      rd(3'd0, v); chk("R2", "seconds wrap", v, 0);
      rd(3'd1, v); chk("R2", "fraction wrap", v, 0);

      // R9 time-of-day alarm
      wr(3'd4, 32'h8000); ticks(2);
      wr(3'd0, 32'hABC1_2344);
      wr(3'd1, 32'hFD);
      wr(3'd2, 32'h12345);
      wr(3'd4, 32'h8003); ticks(2);
      rd(3'd1, v); chk("R6", "no count before run effective", v, 32'hFD);
      ticks(2);
      rd(3'd4, v); chk("R9", "no flag before step", v[6], 0);
      do_tick();
      rd(3'd0, v); chk("R9", "seconds at match", v, 32'hABC1_2345);
      rd(3'd4, v); chk("R9", "tod flag set", v[6], 1);
      chk("R11", "irq/wake on tod", {30'd0, irq, wake}, 32'h3);
      wr(3'd2, 32'h12345);
      rd(3'd4, v); chk("R9", "tod flag cleared", v[6], 0);
      chk("R11", "irq low after clear", {31'd0, irq}, 0);
      rd(3'd5, v); chk("R12", "unused address", v, 0);
      rd(3'd2, v); chk("R12", "alarm readback", v, 32'h12345);

      // R10 sub-second alarm
      wr(3'd3, 32'd3);
      rd(3'd3, v); chk("R12", "reload readback", v, 3);
      ticks(2);
      rd(3'd4, v); chk("R10", "no flag after 2", v[7], 0);
      do_tick();
      rd(3'd4, v); chk("R10", "flag on 3rd update", v[7], 1);
      chk("R11", "flag set but disabled", {30'd0, irq, wake}, 0);
      wr(3'd4, 32'h8007);
      chk("R11", "irq low while busy", {31'd0, irq}, 0);
      ticks(2);
      chk("R11", "irq/wake after enable", {30'd0, irq, wake}, 32'h3);
      wr(3'd3, 32'd2);
      rd(3'd4, v); chk("R10", "reload write clears flag", v[7], 0);
      do_tick();
      rd(3'd4, v); chk("R10", "no flag after 1 of 2", v[7], 0);
      do_tick();
      rd(3'd4, v); chk("R10", "flag after 2 of 2", v[7], 1);
      wr(3'd3, 32'd0);
      ticks(3);
      rd(3'd4, v); chk("R10", "zero reload never fires", v[7], 0);

      // R11 ready interrupt
      wr(3'd4, 32'h8027);
      rd(3'd4, v2); chk("R4", "ctrl after ready-ie write", v2, 32'h8027);
      chk("R11", "irq low, ready clear", {31'd0, irq}, 0);
      do_tick();
      chk("R11", "ready irq, no wake", {30'd0, irq, wake}, 32'h2);

      finish_run();
   end
endmodule